// File: doc/BRIEF.md
# Invalid Block Table Scanner

This block walks every erase block of a page-organised flash device once and builds a table of the blocks that are unusable. For each block it issues a read request for one spare-area byte. That byte is column 517, the sixth of the sixteen spare bytes at columns 512 to 527, and it is read from the first page of the block. The request goes out over a valid/ready request channel and a matching response channel that carries data and an error flag. A block whose marker byte is anything other than FFh is recorded as bad. So is a block whose read returns an error or no response within a bounded number of cycles. After the recording the scan moves on to the next block.

The scan is started by a pulse and visits blocks 0, 1, 2 and so on up to the last block. It keeps one read outstanding at a time. Parameters set the number of blocks (1024 or 2048 on the intended densities) and the pages per block (16 or 32). The block writes nothing to the device: the only traffic it makes is single-byte reads. The finished table can be read by block index with a one-cycle lookup. A busy flag, a done pulse and a running count of bad blocks report on the scan.

Top module: `bad_block_scanner`

## Requirements
- R1: Out of reset busy, done, reqValid and badCount are 0, and a lookup of any index returns 0.
- R2: A start pulse while idle makes busy 1 and reqValid 1 with reqRow 0 on the next cycle, and badCount reads 0 on that cycle.
- R3: Every request carries reqCol = 517 and reqRow = block index times PAGES_PER_BLOCK. Row and valid hold steady while reqReady is low.
- R4: Blocks are requested once each in ascending order from 0 to NUM_BLOCKS-1. The next request is raised only after the previous one has been resolved.
- R5: A response with rspErr = 0 and rspData = FFh marks the block good (lookup 0). Any other data byte marks it bad (lookup 1).
- R6: A response with rspErr = 1 marks the block bad whatever its data byte.
- R7: The first TIMEOUT rising edges after acceptance, counting the accept edge as edge 0, are the only edges at which a response counts. If none arrives in that window the block is marked bad at edge TIMEOUT and the scan goes on.
- R8: rspValid has no effect while no request is outstanding.
- R9: badCount equals the number of blocks marked bad in the current scan. done is a one-cycle pulse on the cycle where busy falls after the last block.
- R10: A start pulse while busy is ignored.
- R11: qryBad shows the table entry for qryIdx one cycle after qryIdx is applied. A new scan overwrites every entry, so a block that was bad earlier and now reads FFh looks up as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a scan (honoured only while idle) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the scan ends |
| badCount | output | $clog2(NUM_BLOCKS+1) | Bad blocks found in the current scan |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Read request accepted |
| reqRow | output | $clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK) | Page address of the block's first page |
| reqCol | output | 10 | Column to read, always 517 |
| rspValid | input | 1 | Response valid |
| rspData | input | 8 | Byte read |
| rspErr | input | 1 | Read failed |
| qryIdx | input | $clog2(NUM_BLOCKS) | Block index to look up |
| qryBad | output | 1 | Table entry for qryIdx, one cycle later |

## Verification
A request appears one cycle after start, or one cycle after the previous block is recorded. A response or timeout sampled at an edge updates the table and badCount at that same edge. done and the fall of busy come at the edge that records the last block, and a lookup answers one edge after its index is applied. The bench keeps a behavioural model stepped on the same rising edge as the design. It compares every output on the following falling edge, so each result is checked in exactly the cycle it is due. Stray responses, busy-time starts, the exact-timeout boundary and a rescan are driven into both model and design.

// File: rtl/bbscan_pkg.sv
package bbscan_pkg;
  localparam int COLW = 10;
  localparam int MARKER_COL = 517;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef struct packed {
    logic scanClr;   // restart at block 0, clear count
    logic waitClr;   // request accepted, zero the response timer
    logic waitTick;  // still waiting, advance the timer
    logic record;    // verdict ready, write table entry
    logic advance;   // move to next block
  } scanStrobe_t;
endpackage

// File: rtl/bbscan_ctrl.sv
module bbscan_ctrl
  import bbscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        reqReady,
  input  logic        rspValid,
  input  logic        timeoutHit,
  input  logic        lastBlk,
  output scanStrobe_t strb,
  output logic        busy,
  output logic        reqValid,
  output logic        scanDone
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} scanState_t;

  scanState_t state, stateNxt;
  logic       doneQ;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.scanClr = 1'b1;
          stateNxt     = S_REQ;
        end
      end
      S_REQ: begin
        if (reqReady) begin
          strb.waitClr = 1'b1;
          stateNxt     = S_WAIT;
        end
      end
      S_WAIT: begin
        if (rspValid || timeoutHit) begin
          strb.record = 1'b1;
          if (lastBlk) begin
            stateNxt = S_IDLE;
          end else begin
            strb.advance = 1'b1;
            stateNxt     = S_REQ;
          end
        end else begin
          strb.waitTick = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= strb.record & lastBlk;
    end
  end

  assign busy     = (state != S_IDLE);
  assign reqValid = (state == S_REQ);
  assign scanDone = doneQ;
endmodule

// File: rtl/bbscan_dp.sv
module bbscan_dp
  import bbscan_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int TIMEOUT         = 4096,
  localparam int IDXW  = $clog2(NUM_BLOCKS),
  localparam int PAGEW = $clog2(PAGES_PER_BLOCK),
  localparam int ROWW  = IDXW + PAGEW,
  localparam int CNTW  = $clog2(NUM_BLOCKS + 1),
  localparam int TMW   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobe_t       strb,
  input  logic              rspValid,
  input  logic [7:0]        rspData,
  input  logic              rspErr,
  input  logic [IDXW-1:0]   qryIdx,
  output logic [ROWW-1:0]   reqRow,
  output logic [COLW-1:0]   reqCol,
  output logic              timeoutHit,
  output logic              lastBlk,
  output logic [CNTW-1:0]   badCount,
  output logic              qryBad
);
  logic [IDXW-1:0]       blkIdx;
  logic [TMW-1:0]        waitTimer;
  logic [NUM_BLOCKS-1:0] badMap;
  logic                  isBad;
  logic                  qryQ;
  logic [CNTW-1:0]       cntQ;

  // no response counts as a failed read
  assign isBad = ~rspValid | rspErr | (rspData != ERASED_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      blkIdx <= '0;
    end else if (strb.scanClr) begin
      blkIdx <= '0;
    end else if (strb.advance) begin
      blkIdx <= blkIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.waitClr) begin
      waitTimer <= '0;
    end else if (strb.waitTick) begin
      waitTimer <= waitTimer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      badMap <= '0;
    end else if (strb.record) begin
      badMap[blkIdx] <= isBad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.scanClr) begin
      cntQ <= '0;
    end else if (strb.record && isBad) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qryQ <= 1'b0;
    end else begin
      qryQ <= badMap[qryIdx];
    end
  end

  generate
    if (PAGEW == 0) begin : g_rowFlat
      assign reqRow = blkIdx;
    end else begin : g_rowShift
      assign reqRow = {blkIdx, {PAGEW{1'b0}}};
    end
  endgenerate

  assign reqCol     = COLW'(MARKER_COL);
  assign timeoutHit = (waitTimer == TMW'(TIMEOUT - 1));
  assign lastBlk    = (blkIdx == IDXW'(NUM_BLOCKS - 1));
  assign badCount   = cntQ;
  assign qryBad     = qryQ;
endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner
  import bbscan_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int TIMEOUT         = 4096,
  localparam int IDXW = $clog2(NUM_BLOCKS),
  localparam int ROWW = IDXW + $clog2(PAGES_PER_BLOCK),
  localparam int CNTW = $clog2(NUM_BLOCKS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [CNTW-1:0] badCount,
  output logic            reqValid,
  input  logic            reqReady,
  output logic [ROWW-1:0] reqRow,
  output logic [9:0]      reqCol,
  input  logic            rspValid,
  input  logic [7:0]      rspData,
  input  logic            rspErr,
  input  logic [IDXW-1:0] qryIdx,
  output logic            qryBad
);
  scanStrobe_t strb;
  logic        timeoutHit;
  logic        lastBlk;

  bbscan_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .timeoutHit (timeoutHit),
    .lastBlk    (lastBlk),
    .strb       (strb),
    .busy       (busy),
    .reqValid   (reqValid),
    .scanDone   (done)
  );

  bbscan_dp #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .TIMEOUT         (TIMEOUT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspErr     (rspErr),
    .qryIdx     (qryIdx),
    .reqRow     (reqRow),
    .reqCol     (reqCol),
    .timeoutHit (timeoutHit),
    .lastBlk    (lastBlk),
    .badCount   (badCount),
    .qryBad     (qryBad)
  );
endmodule

// File: rtl/bad_block_scanner_chk.sv
module bad_block_scanner_chk #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 32,
  localparam int IDXW = $clog2(NUM_BLOCKS),
  localparam int ROWW = IDXW + $clog2(PAGES_PER_BLOCK),
  localparam int CNTW = $clog2(NUM_BLOCKS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [CNTW-1:0] badCount,
  input logic            reqValid,
  input logic            reqReady,
  input logic [ROWW-1:0] reqRow,
  input logic [9:0]      reqCol,
  input logic            rspValid
);
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && reqValid && reqRow == '0 && badCount == '0));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqRow)));

  // R3
  req_addr_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (reqCol == 10'd517 && (int'(reqRow) % PAGES_PER_BLOCK) == 0));

  // R9
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9
  count_mono_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (badCount >= $past(badCount)));

  // R8
  idle_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && rspValid) |=> $stable(badCount));
endmodule

bind bad_block_scanner bad_block_scanner_chk #(
  .NUM_BLOCKS      (NUM_BLOCKS),
  .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .badCount (badCount),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqRow   (reqRow),
  .reqCol   (reqCol),
  .rspValid (rspValid)
);

// File: tb/tb_bad_block_scanner.sv
`timescale 1ns/1ps
module tb_bad_block_scanner;
  localparam int NB   = 16;
  localparam int PPB  = 32;
  localparam int TO   = 8;
  localparam int IDXW = $clog2(NB);
  localparam int ROWW = IDXW + $clog2(PPB);
  localparam int CNTW = $clog2(NB + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            busy, done, reqValid, qryBad;
  logic [CNTW-1:0] badCount;
  logic            reqReady = 1'b0;
  logic [ROWW-1:0] reqRow;
  logic [9:0]      reqCol;
  logic            rspValid = 1'b0;
  logic [7:0]      rspData = 8'h00;
  logic            rspErr = 1'b0;
  logic [IDXW-1:0] qryIdx = '0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int pass = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bad_block_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .badCount(badCount), .reqValid(reqValid), .reqReady(reqReady),
    .reqRow(reqRow), .reqCol(reqCol), .rspValid(rspValid), .rspData(rspData),
    .rspErr(rspErr), .qryIdx(qryIdx), .qryBad(qryBad));

  // stimulus patterns per pass
  function automatic logic [7:0] markerOf(int p, int b);
    if (p == 0) begin
      if (b % 5 == 3) return 8'h00;
      if (b == 7) return 8'hFE;
      return 8'hFF;
    end
    return (b == NB - 1) ? 8'h7F : 8'hFF;
  endfunction
  function automatic bit errOf(int p, int b);
    return (p == 0 && b == 9);
  endfunction
  function automatic int latOf(int p, int b);
    if (p == 0) begin
      if (b == 11) return TO + 3;
      if (b == 12) return TO;
      return (b % 3) + 1;
    end
    return 1;
  endfunction
  function automatic bit expBad(int p, int b);
    return (markerOf(p, b) != 8'hFF) || errOf(p, b) || (latOf(p, b) > TO);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural model, stepped on the same edge as the design
  int mState = 0;  // 0 idle, 1 requesting, 2 waiting
  int mIdx = 0, mTimer = 0, mCount = 0;
  bit mDone = 0, mQry = 0;
  bit mMap[NB];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mState = 0; mIdx = 0; mTimer = 0; mCount = 0; mDone = 0; mQry = 0;
      for (int i = 0; i < NB; i++) mMap[i] = 0;
    end else begin
      mQry  = mMap[qryIdx];
      mDone = 0;
      case (mState)
        0: if (start) begin mState = 1; mIdx = 0; mCount = 0; end
        1: if (reqReady) begin mState = 2; mTimer = 0; end
        default: begin
          if (rspValid || mTimer == TO - 1) begin
            bit bad;
            bad = !rspValid || rspErr || (rspData != 8'hFF);
            mMap[mIdx] = bad;
            mCount += bad;
            if (mIdx == NB - 1) begin mState = 0; mDone = 1; end
            else begin mIdx++; mState = 1; end
          end else mTimer++;
        end
      endcase
    end
  end

  // compare every cycle, then drive the responder
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy == (mState != 0), "R2 R10 busy", busy, mState != 0);
      chk(reqValid == (mState == 1), "R4 reqValid", reqValid, mState == 1);
      if (mState == 1) begin
        chk(reqRow == ROWW'(mIdx * PPB), "R3 R4 reqRow", reqRow, mIdx * PPB);
        chk(reqCol == 10'd517, "R3 reqCol", reqCol, 517);
      end
      chk(done == mDone, "R9 done", done, mDone);
      chk(badCount == CNTW'(mCount), "R8 R9 R10 badCount", badCount, mCount);
      chk(qryBad == mQry, "R11 qryBad", qryBad, mQry);
    end
    reqReady <= (cyc % 3 != 0);
    if (mState == 2 && mTimer == latOf(pass, mIdx) - 1) begin
      rspValid <= 1'b1;
      rspData  <= markerOf(pass, mIdx);
      rspErr   <= errOf(pass, mIdx);
    end else if (mState != 2 && cyc % 4 == 1) begin
      rspValid <= 1'b1;  // stray response, no request outstanding
      rspData  <= 8'h00;
      rspErr   <= 1'b1;
    end else begin
      rspValid <= 1'b0;
      rspData  <= 8'h00;
      rspErr   <= 1'b0;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cyc);
      summary();
    end
  end

  task automatic runScan(input int p, input bit pokeBusy);
    int expCnt;
    expCnt = 0;
    for (int b = 0; b < NB; b++) expCnt += expBad(p, b);
    pass = p;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (pokeBusy) begin
      repeat (20) @(negedge clk);
      start = 1'b1;  // R10: ignored while busy
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R10 busy kept", busy, 1);
    end
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(badCount == CNTW'(expCnt), "R9 final count", badCount, expCnt);
    repeat (10) @(negedge clk);
    chk(badCount == CNTW'(expCnt), "R8 count after strays", badCount, expCnt);
    for (int b = 0; b < NB; b++) begin
      qryIdx = IDXW'(b);
      @(negedge clk);
      if (errOf(p, b))
        chk(qryBad == 1'b1, "R6 error response", qryBad, 1);
      else if (latOf(p, b) > TO)
        chk(qryBad == 1'b1, "R7 timeout", qryBad, 1);
      else if (p == 1)
        chk(qryBad == expBad(p, b), "R11 rescan entry", qryBad, expBad(p, b));
      else
        chk(qryBad == expBad(p, b), "R5 marker verdict", qryBad, expBad(p, b));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(busy == 0 && done == 0 && reqValid == 0, "R1 idle outputs", {busy, done, reqValid}, 0);
    chk(badCount == 0, "R1 count", badCount, 0);
    for (int b = 0; b < NB; b += 5) begin
      qryIdx = IDXW'(b);
      @(negedge clk);
      chk(qryBad == 0, "R1 empty table", qryBad, 0);
    end
    runScan(0, 1'b1);
    // R7 boundary: response exactly at TIMEOUT counts as good
    qryIdx = IDXW'(12);
    @(negedge clk);
    chk(qryBad == 0, "R7 edge response", qryBad, 0);
    runScan(1, 1'b0);
    summary();
  end
endmodule